// File: doc/BRIEF.md
# BCD Time-of-Day Clock

This block keeps wall-clock time as four binary-coded-decimal fields: tenths of a second, seconds, minutes and a 12-hour hour field carrying a PM flag. A one-cycle tick input at either 50 Hz or 60 Hz drives it. A select input chooses which of the two rates is in use. A small divider turns the ticks into tenth-second steps, and the fields then ripple through their decimal rollovers.

Software reaches the clock through four byte-wide slots on a simple 8-bit bus with a chip select, a write enable and a 2-bit address. Two sequencing rules let software read and set the time as a whole. A read of the hour slot freezes a snapshot of all four fields until the tenths slot is read. A write to any lower field stops the count until the hour slot is written.

A second set of four fields, reached by holding an alarm-select input high during writes, holds an alarm time. When the live time first becomes equal to it, a one-cycle pulse goes to an external interrupt controller.

Top module: `tod_clock`

## Requirements
- R1: After reset the time reads 0.0 s, 00 min and hour 0x12 with the PM bit clear (12 AM). The clock is counting and no snapshot is held.
- R2: The slot address selects the field: 0 = tenths (bits 3:0), 1 = seconds (bits 6:0), 2 = minutes (bits 6:0), 3 = hour (bits 4:0 BCD, bit 7 = PM). Unused bits read 0. A read (cs high, we low) returns the field in the same cycle, and rdata is 0 when no read is in progress.
- R3: With sel60 low, every fifth accepted tick advances tenths by one. With sel60 high, every sixth accepted tick does.
- R4: Tenths wrap from 9 to 0 and step the seconds. Seconds and minutes wrap from 59 to 00 and step the next field.
- R5: The hour steps from 11 to 12 and flips the PM bit. It steps from 12 to 01 and leaves the PM bit unchanged.
- R6: With alarm-select low, a write to slot 0, 1 or 2 loads that field and stops the count. Ticks have no effect until the hour slot is written.
- R7: With alarm-select low, a write to slot 3 loads the hour and PM bit and resumes counting. The tick divider restarts from zero.
- R8: A read of slot 3 while no snapshot is held captures all four fields. Later reads of any slot return the captured values while the live count keeps advancing.
- R9: A read of slot 0 returns the snapshot if one is held and then releases it. Later reads show the live count.
- R10: With alarm-select high, writes load the matching alarm field under the same bit masks. They neither stop the clock nor change the time.
- R11: alarm_pulse_o is high for exactly one cycle when the live time becomes equal to the alarm time in all four fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle line-rate tick |
| sel60_i | input | 1 | 1 selects the 60 Hz divisor, 0 selects the 50 Hz divisor |
| cs_i | input | 1 | Bus select |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | ADDR_W | Slot address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational |
| alarm_sel_i | input | 1 | Steers writes to the alarm fields |
| alarm_pulse_o | output | 1 | One-cycle alarm match pulse |

## Verification
The assertions assume that tick_i is a single-cycle pulse and that every value written over the bus is valid BCD within its field's range (hours 01 to 12). With other values the rollover checks no longer describe a meaningful clock. The bench writes only legal BCD times. It produces each tick as a one-cycle pulse between bus accesses, and it changes sel60_i only while the divider is freshly cleared. A behavioural model then tracks the time, snapshot and alarm as integers and compares rdata and the alarm pulse on every cycle.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;

   typedef enum logic [1:0] {
      SLOT_TENTHS = 2'd0,
      SLOT_SEC    = 2'd1,
      SLOT_MIN    = 2'd2,
      SLOT_HOUR   = 2'd3
   } tod_slot_e;

   typedef struct packed {
      logic [3:0] tenths;
      logic [6:0] sec;
      logic [6:0] min;
      logic       pm;
      logic [4:0] hr;
   } tod_time_t;

   localparam logic [4:0] HOUR_RESET = 5'h12;

   function automatic logic [7:0] slot_byte(input tod_time_t t, input tod_slot_e s);
      case (s)
         SLOT_TENTHS: return {4'h0, t.tenths};
         SLOT_SEC:    return {1'b0, t.sec};
         SLOT_MIN:    return {1'b0, t.min};
         default:     return {t.pm, 2'b00, t.hr};
      endcase
   endfunction

endpackage

// File: rtl/tod_prescaler.sv
`timescale 1ns/1ps
module tod_prescaler #(
   parameter int unsigned SLOW_TICKS = 5,
   parameter int unsigned FAST_TICKS = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic run_i,
   input  logic tick_i,
   input  logic sel_fast_i,
   output logic step_o
);
   localparam int unsigned MAX_TICKS = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
   localparam int unsigned CNT_W     = $clog2(MAX_TICKS);

   if (SLOW_TICKS < 2 || FAST_TICKS < 2) begin : g_bad_ticks
      $error("tod_prescaler: divisors must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_val;
   logic             at_last;

   if (SLOW_TICKS == FAST_TICKS) begin : g_single_rate
      assign last_val = CNT_W'(SLOW_TICKS - 1);
   end else begin : g_dual_rate
      assign last_val = sel_fast_i ? CNT_W'(FAST_TICKS - 1) : CNT_W'(SLOW_TICKS - 1);
   end

   assign at_last = (cnt_q >= last_val);
   assign step_o  = run_i & tick_i & at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clear_i)        cnt_q <= '0;
      else if (run_i & tick_i) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
   end

   // R3: a step leaves the divider at zero, so two steps never touch
   assert_step_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |=> !step_o);

   // R7: a clear leaves no partial count behind
   assert_clear_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !step_o || (last_val == '0));

endmodule

// File: rtl/tod_bcd_field.sv
`timescale 1ns/1ps
module tod_bcd_field #(
   parameter int unsigned WIDTH   = 7,
   parameter logic [7:0]  MAX_BCD = 8'h59
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] load_val_i,
   input  logic             inc_i,
   output logic [WIDTH-1:0] value_o,
   output logic             carry_o
);
   if (WIDTH < 4 || WIDTH > 8) begin : g_bad_width
      $error("tod_bcd_field: WIDTH must be 4..8");
   end
   if (MAX_BCD[3:0] > 4'd9) begin : g_bad_max
      $error("tod_bcd_field: MAX_BCD low digit is not decimal");
   end

   logic [WIDTH-1:0] val_q;
   logic [WIDTH-1:0] nxt;
   logic             at_max;

   assign at_max = (val_q == MAX_BCD[WIDTH-1:0]);

   if (WIDTH > 4) begin : g_two_digit
      always_comb begin
         if (at_max)                  nxt = '0;
         else if (val_q[3:0] >= 4'd9) nxt = {val_q[WIDTH-1:4] + 1'b1, 4'h0};
         else                         nxt = val_q + 1'b1;
      end
   end else begin : g_one_digit
      always_comb nxt = at_max ? '0 : val_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q <= '0;
      else if (load_i) val_q <= load_val_i;
      else if (inc_i)  val_q <= nxt;
   end

   assign value_o = val_q;
   assign carry_o = inc_i & at_max;

   // R4: stepping past the top value lands on zero
   assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (carry_o && !load_i) |=> (value_o == '0));

   // R6: without load or step the field holds
   assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !inc_i) |=> $stable(value_o));

endmodule

// File: rtl/tod_hour_field.sv
`timescale 1ns/1ps
module tod_hour_field
   import tod_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  logic       load_pm_i,
   input  logic [4:0] load_hr_i,
   input  logic       inc_i,
   output logic       pm_o,
   output logic [4:0] hr_o
);
   logic [4:0] hr_q, hr_nxt;
   logic       pm_q, pm_nxt;

   always_comb begin
      hr_nxt = hr_q + 1'b1;
      pm_nxt = pm_q;
      if (hr_q == 5'h12) begin
         hr_nxt = 5'h01;
      end else if (hr_q == 5'h11) begin
         hr_nxt = 5'h12;
         pm_nxt = ~pm_q;
      end else if (hr_q[3:0] >= 4'd9) begin
         hr_nxt = 5'h10;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hr_q <= HOUR_RESET;
         pm_q <= 1'b0;
      end else if (load_i) begin
         hr_q <= load_hr_i;
         pm_q <= load_pm_i;
      end else if (inc_i) begin
         hr_q <= hr_nxt;
         pm_q <= pm_nxt;
      end
   end

   assign pm_o = pm_q;
   assign hr_o = hr_q;

   // R5: eleven to twelve flips the half-day flag
   assert_pm_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i && hr_o == 5'h11) |=> (hr_o == 5'h12) && (pm_o != $past(pm_o)));

   // R5: twelve to one keeps the half-day flag
   assert_twelve_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i && hr_o == 5'h12) |=> (hr_o == 5'h01) && $stable(pm_o));

endmodule

// File: rtl/tod_alarm.sv
`timescale 1ns/1ps
module tod_alarm
   import tod_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_i,
   input  tod_slot_e  slot_i,
   input  logic [7:0] wdata_i,
   input  tod_time_t  live_i,
   output logic       pulse_o
);
   tod_time_t alm_q;
   logic      match, match_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alm_q <= '0;
      end else if (wr_i) begin
         case (slot_i)
            SLOT_TENTHS: alm_q.tenths <= wdata_i[3:0];
            SLOT_SEC:    alm_q.sec    <= wdata_i[6:0];
            SLOT_MIN:    alm_q.min    <= wdata_i[6:0];
            default: begin
               alm_q.hr <= wdata_i[4:0];
               alm_q.pm <= wdata_i[7];
            end
         endcase
      end
   end

   assign match = (alm_q == live_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= 1'b0;
      else        match_q <= match;
   end

   assign pulse_o = match & ~match_q;

   // R11: the pulse never lasts two cycles
   assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);

endmodule

// File: rtl/tod_clock.sv
`timescale 1ns/1ps
module tod_clock
   import tod_pkg::*;
#(
   parameter int unsigned TICKS_50HZ = 5,
   parameter int unsigned TICKS_60HZ = 6,
   parameter int unsigned ADDR_W     = 2,
   parameter int unsigned DATA_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              sel60_i,
   input  logic              cs_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              alarm_sel_i,
   output logic              alarm_pulse_o
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("tod_clock: ADDR_W must be at least 2");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("tod_clock: DATA_W must be 8");
   end

   logic      sel_ok;
   tod_slot_e slot;
   logic      acc, rd, wr_time, wr_alarm, wr_low, wr_hour;
   logic      run_q, run_gate, step;
   logic      lat_q;
   tod_time_t snap_q, live, view;
   logic      c_tenths, c_sec, c_min;

   if (ADDR_W > 2) begin : g_wide_addr
      assign sel_ok = (addr_i[ADDR_W-1:2] == '0);
   end else begin : g_narrow_addr
      assign sel_ok = 1'b1;
   end

   assign slot     = tod_slot_e'(addr_i[1:0]);
   assign acc      = cs_i & sel_ok;
   assign rd       = acc & ~we_i;
   assign wr_time  = acc & we_i & ~alarm_sel_i;
   assign wr_alarm = acc & we_i & alarm_sel_i;
   assign wr_hour  = wr_time & (slot == SLOT_HOUR);
   assign wr_low   = wr_time & (slot != SLOT_HOUR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= 1'b1;
      else if (wr_hour) run_q <= 1'b1;
      else if (wr_low)  run_q <= 1'b0;
   end

   assign run_gate = run_q & ~wr_time;

   tod_prescaler #(
      .SLOW_TICKS (TICKS_50HZ),
      .FAST_TICKS (TICKS_60HZ)
   ) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (wr_hour),
      .run_i      (run_gate),
      .tick_i     (tick_i),
      .sel_fast_i (sel60_i),
      .step_o     (step)
   );

   tod_bcd_field #(.WIDTH(4), .MAX_BCD(8'h09)) u_tenths (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (wr_time & (slot == SLOT_TENTHS)),
      .load_val_i (wdata_i[3:0]),
      .inc_i      (step),
      .value_o    (live.tenths),
      .carry_o    (c_tenths)
   );

   tod_bcd_field #(.WIDTH(7), .MAX_BCD(8'h59)) u_sec (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (wr_time & (slot == SLOT_SEC)),
      .load_val_i (wdata_i[6:0]),
      .inc_i      (c_tenths),
      .value_o    (live.sec),
      .carry_o    (c_sec)
   );

   tod_bcd_field #(.WIDTH(7), .MAX_BCD(8'h59)) u_min (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (wr_time & (slot == SLOT_MIN)),
      .load_val_i (wdata_i[6:0]),
      .inc_i      (c_sec),
      .value_o    (live.min),
      .carry_o    (c_min)
   );

   tod_hour_field u_hour (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (wr_hour),
      .load_pm_i (wdata_i[7]),
      .load_hr_i (wdata_i[4:0]),
      .inc_i     (c_min),
      .pm_o      (live.pm),
      .hr_o      (live.hr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q  <= 1'b0;
         snap_q <= '0;
      end else if (rd && slot == SLOT_HOUR && !lat_q) begin
         lat_q  <= 1'b1;
         snap_q <= live;
      end else if (rd && slot == SLOT_TENTHS) begin
         lat_q  <= 1'b0;
      end
   end

   assign view    = lat_q ? snap_q : live;
   assign rdata_o = rd ? DATA_W'(slot_byte(view, slot)) : '0;

   tod_alarm u_alarm (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_alarm),
      .slot_i  (slot),
      .wdata_i (wdata_i[7:0]),
      .live_i  (live),
      .pulse_o (alarm_pulse_o)
   );

   // R6: a lower-field write halts the count
   assert_halt_on_low_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_low |=> !run_q);

   // R6: while halted and not written, the time is frozen
   assert_frozen_when_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !wr_time) |=> $stable(live));

   // R7: an hour write resumes counting
   assert_restart_on_hour_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hour |=> run_q);

   // R8: a first hour read takes a snapshot
   assert_latch_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && slot == SLOT_HOUR && !lat_q) |=> lat_q);

   // R8: a held snapshot does not move
   assert_snapshot_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q && !(rd && slot == SLOT_TENTHS)) |=> lat_q && $stable(snap_q));

   // R9: a tenths read drops the snapshot
   assert_release_on_tenths_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && slot == SLOT_TENTHS) |=> !lat_q);

   // R10: alarm writes leave the running state alone
   assert_alarm_write_no_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_alarm && run_q) |=> run_q);

endmodule

// File: tb/tod_clock_bench.sv
`timescale 1ns/1ps
module tod_clock_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       sel60_i = 1'b0;
   logic       cs_i = 1'b0;
   logic       we_i = 1'b0;
   logic [1:0] addr_i = 2'd0;
   logic [7:0] wdata_i = 8'h00;
   logic       alarm_sel_i = 1'b0;
   logic [7:0] rdata_o;
   logic       alarm_pulse_o;

   always #10 clk = ~clk;

   tod_clock u_tod_clock (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick_i        (tick_i),
      .sel60_i       (sel60_i),
      .cs_i          (cs_i),
      .we_i          (we_i),
      .addr_i        (addr_i),
      .wdata_i       (wdata_i),
      .rdata_o       (rdata_o),
      .alarm_sel_i   (alarm_sel_i),
      .alarm_pulse_o (alarm_pulse_o)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   int    n_pulses = 0;
   string cur_req = "R1";
   bit    finished = 1'b0;

   // ---------------- behavioural reference ----------------
   int         m_t, m_s, m_m, m_h, m_pre;
   bit         m_pm, m_run, m_lat, m_prev, m_exp_pulse;
   logic [7:0] m_snap [4];
   logic [7:0] m_alm  [4];

   function automatic logic [7:0] to_bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int from_bcd(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic logic [7:0] field_mask(input int idx);
      case (idx)
         0:       return 8'h0F;
         1, 2:    return 8'h7F;
         default: return 8'h9F;
      endcase
   endfunction

   function automatic logic [7:0] live_byte(input int idx);
      logic [7:0] hb;
      hb = to_bcd(m_h);
      case (idx)
         0:       return to_bcd(m_t);
         1:       return to_bcd(m_s);
         2:       return to_bcd(m_m);
         default: return {m_pm, 2'b00, hb[4:0]};
      endcase
   endfunction

   function automatic bit model_match();
      for (int i = 0; i < 4; i++)
         if (live_byte(i) != m_alm[i]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic model_advance();
      m_t++;
      if (m_t == 10) begin
         m_t = 0; m_s++;
         if (m_s == 60) begin
            m_s = 0; m_m++;
            if (m_m == 60) begin
               m_m = 0;
               if (m_h == 11) begin m_h = 12; m_pm = ~m_pm; end
               else if (m_h == 12) m_h = 1;
               else m_h++;
            end
         end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_t = 0; m_s = 0; m_m = 0; m_h = 12; m_pm = 0;
         m_pre = 0; m_run = 1; m_lat = 0; m_prev = 0; m_exp_pulse = 0;
         for (int i = 0; i < 4; i++) begin m_snap[i] = 8'h00; m_alm[i] = 8'h00; end
      end else begin
         m_prev = model_match();
         if (cs_i && !we_i && addr_i == 2'd3 && !m_lat) begin
            m_lat = 1;
            for (int i = 0; i < 4; i++) m_snap[i] = live_byte(i);
         end else if (cs_i && !we_i && addr_i == 2'd0) begin
            m_lat = 0;
         end
         if (cs_i && we_i && alarm_sel_i)
            m_alm[addr_i] = wdata_i & field_mask(int'(addr_i));
         if (cs_i && we_i && !alarm_sel_i) begin
            case (addr_i)
               2'd0: begin m_t = from_bcd(wdata_i & 8'h0F); m_run = 0; end
               2'd1: begin m_s = from_bcd(wdata_i & 8'h7F); m_run = 0; end
               2'd2: begin m_m = from_bcd(wdata_i & 8'h7F); m_run = 0; end
               default: begin
                  m_h = from_bcd(wdata_i & 8'h1F); m_pm = wdata_i[7];
                  m_run = 1; m_pre = 0;
               end
            endcase
         end else if (m_run && tick_i) begin
            m_pre++;
            if (m_pre >= (sel60_i ? 6 : 5)) begin
               m_pre = 0;
               model_advance();
            end
         end
         m_exp_pulse = model_match() && !m_prev;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [7:0] exp_rd;
         if (cs_i && !we_i) exp_rd = m_lat ? m_snap[addr_i] : live_byte(int'(addr_i));
         else               exp_rd = 8'h00;
         chk({cur_req, " rdata"}, rdata_o, exp_rd);
         chk("R11 pulse", {7'd0, alarm_pulse_o}, {7'd0, m_exp_pulse});
         if (alarm_pulse_o) n_pulses++;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input bit asel, input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #5;
      cs_i = 1; we_i = 1; alarm_sel_i = asel; addr_i = a; wdata_i = d;
      @(posedge clk); #5;
      cs_i = 0; we_i = 0; alarm_sel_i = 0; wdata_i = 8'h00;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(posedge clk); #5;
      cs_i = 1; we_i = 0; addr_i = a;
      #1 d = rdata_o;
      @(posedge clk); #5;
      cs_i = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #5; tick_i = 1;
         @(posedge clk); #5; tick_i = 0;
      end
   endtask

   task automatic set_time(input logic [7:0] t, input logic [7:0] s,
                           input logic [7:0] m, input logic [7:0] h);
      wr(0, 2'd0, t); wr(0, 2'd1, s); wr(0, 2'd2, m); wr(0, 2'd3, h);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         finished = 1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(posedge clk);
      #5 rst_n = 1;

      // R1 / R2: reset contents through each slot
      cur_req = "R1";
      rd(2'd0, v); chk("R1 tenths", v, 8'h00);
      rd(2'd1, v); chk("R1 seconds", v, 8'h00);
      rd(2'd2, v); chk("R1 minutes", v, 8'h00);
      rd(2'd3, v); chk("R2 hour slot", v, 8'h12);
      rd(2'd0, v);

      // R3: 50 Hz divisor
      cur_req = "R3";
      wr(0, 2'd3, 8'h01);
      ticks(4); rd(2'd0, v); chk("R3 50Hz four ticks", v, 8'h00);
      ticks(1); rd(2'd0, v); chk("R3 50Hz fifth tick", v, 8'h01);
      // R3: 60 Hz divisor, divider cleared by hour write
      sel60_i = 1; wr(0, 2'd3, 8'h01);
      ticks(5); rd(2'd0, v); chk("R3 60Hz five ticks", v, 8'h01);
      ticks(1); rd(2'd0, v); chk("R3 60Hz sixth tick", v, 8'h02);
      sel60_i = 0; wr(0, 2'd3, 8'h01);

      // R4 / R5: full ripple, 11 to 12 sets PM
      cur_req = "R4";
      set_time(8'h09, 8'h59, 8'h59, 8'h11);
      ticks(5);
      rd(2'd1, v); chk("R4 seconds wrap", v, 8'h00);
      rd(2'd2, v); chk("R4 minutes wrap", v, 8'h00);
      rd(2'd3, v); chk("R5 11->12 PM", v, 8'h92);
      rd(2'd0, v); chk("R4 tenths wrap", v, 8'h00);

      // R5: 12 PM to 1 PM, 11 PM to 12 AM
      cur_req = "R5";
      set_time(8'h09, 8'h59, 8'h59, 8'h92);
      ticks(5); rd(2'd3, v); chk("R5 12->01 keeps PM", v, 8'h81); rd(2'd0, v);
      set_time(8'h09, 8'h59, 8'h59, 8'h91);
      ticks(5); rd(2'd3, v); chk("R5 11PM->12AM", v, 8'h12); rd(2'd0, v);
      set_time(8'h09, 8'h59, 8'h59, 8'h09);
      ticks(5); rd(2'd3, v); chk("R5 09->10", v, 8'h10); rd(2'd0, v);

      // R6: a lower write halts counting
      cur_req = "R6";
      wr(0, 2'd0, 8'h03);
      ticks(12); rd(2'd0, v); chk("R6 halted tenths", v, 8'h03);
      wr(0, 2'd1, 8'h20);
      ticks(6); rd(2'd1, v); chk("R6 halted seconds", v, 8'h20);

      // R7: hour write restarts and clears the divider
      cur_req = "R7";
      wr(0, 2'd3, 8'h02);
      ticks(5); rd(2'd0, v); chk("R7 resumed", v, 8'h04);
      ticks(3); wr(0, 2'd3, 8'h02);
      ticks(4); rd(2'd0, v); chk("R7 divider cleared", v, 8'h04);
      ticks(1); rd(2'd0, v); chk("R7 step after clear", v, 8'h05);

      // R8 / R9: snapshot and release
      cur_req = "R8";
      set_time(8'h09, 8'h59, 8'h59, 8'h03);
      rd(2'd3, v); chk("R8 hour read", v, 8'h03);
      ticks(5);
      rd(2'd2, v); chk("R8 snapshot minutes", v, 8'h59);
      rd(2'd1, v); chk("R8 snapshot seconds", v, 8'h59);
      rd(2'd3, v); chk("R8 snapshot hour held", v, 8'h03);
      cur_req = "R9";
      rd(2'd0, v); chk("R9 tenths from snapshot", v, 8'h09);
      rd(2'd0, v); chk("R9 live after release", v, 8'h00);
      rd(2'd2, v); chk("R9 live minutes", v, 8'h00);

      // R10: alarm writes do not touch time
      cur_req = "R10";
      wr(1, 2'd0, 8'h02); wr(1, 2'd1, 8'h00);
      wr(1, 2'd2, 8'h00); wr(1, 2'd3, 8'h04);
      rd(2'd0, v); chk("R10 time unchanged", v, 8'h00);
      ticks(5); rd(2'd0, v); chk("R10 still running", v, 8'h01);

      // R11: single pulse on match
      cur_req = "R11";
      chk("R11 no pulse yet", 8'(n_pulses), 8'd0);
      ticks(5); repeat (3) @(posedge clk);
      chk("R11 one pulse at match", 8'(n_pulses), 8'd1);
      ticks(10); rd(2'd0, v);
      chk("R11 no repeat", 8'(n_pulses), 8'd1);
      chk("R11 time past alarm", v, 8'h04);

      repeat (4) @(posedge clk);
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule